// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Speed Window

This block turns the two phase lines and the index line of an incremental encoder into a 32-bit position count, a direction flag and a periodic speed value. All three inputs pass a two-flop synchronizer. The decoder works in one of two ways. In quadrature mode it counts either every edge of both phases or only the edges of phase A. In clock/direction mode it counts each rising edge of phase A, and the level of phase B sets whether the count goes up or down. A swap control exchanges the two phases before they are decoded.

The position wraps at a programmable ceiling or returns to zero on an index pulse, depending on the reset mode. Software can load the position at any time. A velocity timer defines a fixed window. The counted edges, after a power-of-two predivider, are summed over that window and copied into a speed register when the window closes. A single register port gives software access to the control word, status, position, ceiling, window length and speed. Clearing the enable bit holds the counting and the timing but still accepts register writes.

Top module: `qdec_top`

## Requirements
- R1: Register addresses (reg_addr): 0 control, 1 status, 2 position, 3 ceiling, 4 window load, 5 speed. Reads of 6 and 7 return 0. Control bits: 0 enable, 1 index reset mode (0 selects ceiling mode), 2 count both phases, 3 velocity enable, 4 clock/direction mode, 5 swap, 8:6 predivider exponent k.
- R2: After reset, position, control, speed and status read 0, the ceiling reads all ones and the window load reads 1200000.
- R3: In quadrature mode with both-phase counting, each change of a single phase moves the position by one, so a full encoder cycle moves it by four. The order A rises, B rises, A falls, B falls counts up. A change of both phases in the same sample is not counted. A position change is visible three clock edges after the input changes.
- R4: In quadrature mode with both-phase counting off, only changes of A while B holds are counted, which gives two counts per encoder cycle.
- R5: In clock/direction mode, a rising edge of A counts up when B is low and counts down when B is high. Falling edges of A and changes of B do not count.
- R6: With swap set, A and B are exchanged before decoding, so the sequence that counts up without swap counts down.
- R7: In ceiling mode, counting up from the ceiling gives 0 and counting down from 0 gives the ceiling.
- R8: In index mode, a rising index edge sets the position to 0, and this wins over a count in the same cycle. In this mode the count wraps over the full 32-bit range and ignores the ceiling.
- R9: A write to the position register takes effect on the next clock edge and wins over any count or index event in that cycle.
- R10: Status bit 0 reads 0 after a count up and 1 after a count down.
- R11: With velocity enabled, a window lasts load+1 cycles. When it closes, the accumulated count goes into the speed register and the accumulator clears. Writing the load register restarts the window, clears the accumulator and clears the predivider.
- R12: The predivider passes one count into the accumulator for every 2^k counted edges, with k from 0 to 7.
- R13: With enable clear, the position, speed and window timer hold, and register writes still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| idx | input | 1 | Encoder index, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Two events can land on the position register in the same cycle. The first case is an index edge and a phase edge that arrive together. The bench changes idx and a phase in the same half-cycle, so both leave the synchronizer in the same cycle, and it then expects the position to read 0 and not the counted value. The second case is a software position write that meets a count. The bench times the write strobe two cycles after a phase edge, so the write lands on the same clock edge as the step, and it expects the written value with no count added. Clocked properties cover the same two priority rules on every cycle of the random phase walk.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int AW     = 3;
    localparam int PDW    = 3;
    localparam int PREW   = (1 << PDW) - 1;

    typedef enum logic [AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_POS   = 3'd2,
        RA_CEIL  = 3'd3,
        RA_LOAD  = 3'd4,
        RA_SPEED = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [PDW-1:0] prediv;
        logic           swap;
        logic           clkdir;
        logic           vel_en;
        logic           cap_both;
        logic           rst_idx;
        logic           en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic up;
        logic dn;
        logic idx;
    } evt_t;

    function automatic logic [PREW-1:0] pre_mask(input logic [PDW-1:0] k);
        logic [PREW:0] one;
        logic [PREW:0] t;
        one = {{PREW{1'b0}}, 1'b1};
        t   = (one << k) - one;
        return t[PREW-1:0];
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic swap,
    input  logic clkdir,
    input  logic cap_both,
    input  logic a_s,
    input  logic b_s,
    input  logic i_s,
    output evt_t ev
);
    logic a, b, a_p, b_p, i_p;
    logic da, db, cnt, fwd;

    always_comb begin
        a = swap ? b_s : a_s;
        b = swap ? a_s : b_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
            i_p <= 1'b0;
        end else begin
            a_p <= a;
            b_p <= b;
            i_p <= i_s;
        end
    end

    always_comb begin
        da = a ^ a_p;
        db = b ^ b_p;
        if (clkdir) begin
            cnt = a & ~a_p;
            fwd = ~b;
        end else begin
            cnt = cap_both ? (da ^ db) : (da & ~db);
            fwd = da ? (a ^ b) : ~(a ^ b);
        end
        ev.up  = en & cnt & fwd;
        ev.dn  = en & cnt & ~fwd;
        ev.idx = en & i_s & ~i_p;
    end
endmodule

// File: rtl/qdec_velocity.sv
module qdec_velocity
    import qdec_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int unsigned DEF_LOAD = 1200000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           vel_en,
    input  logic           step,
    input  logic [PDW-1:0] prediv,
    input  logic           load_wr,
    input  logic [DW-1:0]  load_in,
    output logic [DW-1:0]  load_q,
    output logic [DW-1:0]  speed_q,
    output logic           win_end
);
    logic [PREW-1:0] pre, mask;
    logic [DW-1:0]   timer, acc, inc;
    logic            pulse;

    always_comb begin
        mask    = pre_mask(prediv);
        pulse   = step & (pre == mask);
        inc     = {{(DW-1){1'b0}}, pulse};
        win_end = run & vel_en & (timer == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q  <= DW'(DEF_LOAD);
            timer   <= DW'(DEF_LOAD);
            acc     <= '0;
            pre     <= '0;
            speed_q <= '0;
        end else if (load_wr) begin
            load_q <= load_in;
            timer  <= load_in;
            acc    <= '0;
            pre    <= '0;
        end else if (!vel_en) begin
            timer <= load_q;
            acc   <= '0;
            pre   <= '0;
        end else if (run) begin
            if (step) pre <= pulse ? '0 : pre + PREW'(1);
            if (win_end) begin
                speed_q <= acc + inc;
                acc     <= '0;
                timer   <= load_q;
            end else begin
                acc   <= acc + inc;
                timer <= timer - DW'(1);
            end
        end
    end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int unsigned DEF_LOAD = 1200000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ph_a,
    input  logic          ph_b,
    input  logic          idx,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);
    logic [2:0]    sy;
    ctrl_t         ctrl_q;
    evt_t          ev;
    logic [DW-1:0] pos_q, ceil_q, load_q, speed_q;
    logic          dir_q, pos_wr, load_wr, win_end;
    reg_sel_e      sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign pos_wr  = reg_we && (sel == RA_POS);
    assign load_wr = reg_we && (sel == RA_LOAD);

    qdec_sync #(.N(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({idx, ph_b, ph_a}),
        .q   (sy)
    );

    qdec_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .swap     (ctrl_q.swap),
        .clkdir   (ctrl_q.clkdir),
        .cap_both (ctrl_q.cap_both),
        .a_s      (sy[0]),
        .b_s      (sy[1]),
        .i_s      (sy[2]),
        .ev       (ev)
    );

    qdec_velocity #(.DW(DW), .DEF_LOAD(DEF_LOAD)) u_vel (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.en),
        .vel_en  (ctrl_q.vel_en),
        .step    (ev.up | ev.dn),
        .prediv  (ctrl_q.prediv),
        .load_wr (load_wr),
        .load_in (reg_wdata),
        .load_q  (load_q),
        .speed_q (speed_q),
        .win_end (win_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ceil_q <= '1;
        end else if (reg_we) begin
            if (sel == RA_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (sel == RA_CEIL) ceil_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            dir_q <= 1'b0;
        end else begin
            if (ev.up)      dir_q <= 1'b0;
            else if (ev.dn) dir_q <= 1'b1;

            if (pos_wr) begin
                pos_q <= reg_wdata;
            end else if (ctrl_q.rst_idx && ev.idx) begin
                pos_q <= '0;
            end else if (ev.up) begin
                pos_q <= (!ctrl_q.rst_idx && pos_q == ceil_q) ? '0 : pos_q + DW'(1);
            end else if (ev.dn) begin
                if (pos_q == '0) pos_q <= ctrl_q.rst_idx ? '1 : ceil_q;
                else             pos_q <= pos_q - DW'(1);
            end
        end
    end

    always_comb begin
        case (sel)
            RA_CTRL:  reg_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            RA_STAT:  reg_rdata = {{(DW-1){1'b0}}, dir_q};
            RA_POS:   reg_rdata = pos_q;
            RA_CEIL:  reg_rdata = ceil_q;
            RA_LOAD:  reg_rdata = load_q;
            RA_SPEED: reg_rdata = speed_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          rst_idx,
    input logic          step_up,
    input logic          step_dn,
    input logic          idx_rise,
    input logic          pos_wr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] pos_q,
    input logic [DW-1:0] ceil_q,
    input logic          dir_q,
    input logic [DW-1:0] speed_q,
    input logic          win_end
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !pos_wr) |=> $stable(pos_q)); // R13

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (!rst_idx && step_up && !pos_wr && pos_q == ceil_q) |=> (pos_q == '0)); // R7

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!rst_idx && step_dn && !pos_wr && pos_q == '0) |=> (pos_q == $past(ceil_q))); // R7

    AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rst_idx && idx_rise && !pos_wr) |=> (pos_q == '0)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        pos_wr |=> (pos_q == $past(wdata))); // R9

    AST_DIR_FWD: assert property (@(posedge clk) disable iff (rst)
        step_up |=> !dir_q); // R10

    AST_DIR_REV: assert property (@(posedge clk) disable iff (rst)
        step_dn |=> dir_q); // R10

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(speed_q)); // R11
endmodule

bind qdec_top qdec_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q.en),
    .rst_idx  (ctrl_q.rst_idx),
    .step_up  (ev.up),
    .step_dn  (ev.dn),
    .idx_rise (ev.idx),
    .pos_wr   (pos_wr),
    .wdata    (reg_wdata),
    .pos_q    (pos_q),
    .ceil_q   (ceil_q),
    .dir_q    (dir_q),
    .speed_q  (speed_q),
    .win_end  (win_end)
);

// File: tb/test_qdec_top.sv
module test_qdec_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ph_a = 1'b0, ph_b = 1'b0, idx = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic ca = 1'b0, cb = 1'b0;

    always #2.5 clk = ~clk;

    qdec_top i_qdec_top (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b), .idx(idx),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    localparam logic [31:0] C_EN = 32'h1, C_IDX = 32'h2, C_BOTH = 32'h4,
                            C_VEL = 32'h8, C_CD = 32'h10, C_SWAP = 32'h20;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        ph_a = a; ph_b = b; ca = a; cb = b;
        repeat (4) @(negedge clk);
    endtask

    // Gray position: 00 -> 10 -> 11 -> 01 counts up (A leads B)
    function automatic int gidx(input logic a, input logic b);
        return a ? (b ? 2 : 1) : (b ? 3 : 0);
    endfunction

    function automatic logic [1:0] gst(input int g);
        case (g)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int qdelta(input logic oa, ob, na, nb);
        int d;
        d = (gidx(na, nb) - gidx(oa, ob) + 4) % 4;
        return (d == 1) ? 1 : (d == 3) ? -1 : 0;
    endfunction

    function automatic logic [31:0] mstep(input logic [31:0] p, input int d,
                                          input logic [31:0] mx, input bit im);
        if (d == 1)  return (!im && p == mx) ? 32'd0 : p + 32'd1;
        if (d == -1) return (p == 0) ? (im ? 32'hFFFF_FFFF : mx) : p - 32'd1;
        return p;
    endfunction

    task automatic step_dir(input bit fwd);
        logic [1:0] s;
        s = gst((gidx(ca, cb) + (fwd ? 1 : 3)) % 4);
        drive(s[1], s[0]);
    endtask

    task automatic vel_case(input int k, input int n, input logic [31:0] exp);
        logic [31:0] v;
        wr(3'd0, C_EN | C_BOTH | C_VEL | (32'(k) << 6));
        wr(3'd4, 32'd999);
        for (int i = 0; i < n; i++) step_dir(1'b1);
        repeat (1300 - 4 * n) @(negedge clk);
        rd(3'd5, v); check("R11/R12 speed after window", v, exp);
        repeat (1000) @(negedge clk);
        rd(3'd5, v); check("R11 speed after empty window", v, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, expp;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1, R2: defaults and map
        rd(3'd0, v); check("R2 ctrl reset", v, 32'd0);
        rd(3'd1, v); check("R2 status reset", v, 32'd0);
        rd(3'd2, v); check("R2 position reset", v, 32'd0);
        rd(3'd3, v); check("R2 ceiling reset", v, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R2 load reset", v, 32'd1200000);
        rd(3'd5, v); check("R2 speed reset", v, 32'd0);
        rd(3'd6, v); check("R1 unused address", v, 32'd0);

        // R13: disabled holds position, writes still apply
        for (int i = 0; i < 4; i++) step_dir(1'b1);
        rd(3'd2, v); check("R13 position held while disabled", v, 32'd0);
        wr(3'd2, 32'd6);
        rd(3'd2, v); check("R13 write while disabled", v, 32'd6);
        wr(3'd3, 32'd9);
        wr(3'd2, 32'd0);

        // R3: one full cycle in both-phase quadrature
        wr(3'd0, C_EN | C_BOTH);
        rd(3'd0, v); check("R1 ctrl readback", v, C_EN | C_BOTH);
        for (int i = 0; i < 4; i++) step_dir(1'b1);
        rd(3'd2, v); check("R3 four counts per cycle", v, 32'd4);
        rd(3'd1, v); check("R10 forward status", v, 32'd0);

        // R3: simultaneous change ignored
        begin
            logic [1:0] s;
            s = gst((gidx(ca, cb) + 2) % 4);
            drive(s[1], s[0]);
        end
        rd(3'd2, v); check("R3 both-phase change ignored", v, 32'd4);

        // R7, R10: random walk with ceiling 9
        expp = 32'd4;
        for (int n = 0; n < 300; n++) begin
            logic oa, ob;
            bit fwd;
            oa = ca; ob = cb;
            fwd = ($urandom % 2) == 0;
            step_dir(fwd);
            expp = mstep(expp, qdelta(oa, ob, ca, cb), 32'd9, 1'b0);
            rd(3'd2, v); check("R7 random walk position", v, expp);
            rd(3'd1, v); check("R10 random walk direction", v, fwd ? 32'd0 : 32'd1);
        end

        // R7 directed wrap both ways
        wr(3'd2, 32'd9); step_dir(1'b1);
        rd(3'd2, v); check("R7 wrap up to zero", v, 32'd0);
        step_dir(1'b0);
        rd(3'd2, v); check("R7 wrap down to ceiling", v, 32'd9);

        // R9: write lands on the same edge as a count
        wr(3'd2, 32'd3);
        begin
            logic [1:0] s;
            s = gst((gidx(ca, cb) + 1) % 4);
            @(negedge clk); ph_a = s[1]; ph_b = s[0]; ca = s[1]; cb = s[0];
            @(negedge clk);
            @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd7;
            @(negedge clk); reg_we = 1'b0;
            repeat (3) @(negedge clk);
        end
        rd(3'd2, v); check("R9 write wins over count", v, 32'd7);
        step_dir(1'b1);
        rd(3'd2, v); check("R9 counting resumes", v, 32'd8);

        // R4: A-only capture
        wr(3'd0, C_EN); wr(3'd2, 32'd0);
        for (int i = 0; i < 4; i++) step_dir(1'b1);
        rd(3'd2, v); check("R4 A-only two per cycle", v, 32'd2);

        // R6: swap reverses the count
        wr(3'd0, C_EN | C_BOTH | C_SWAP); wr(3'd2, 32'd8);
        for (int i = 0; i < 4; i++) step_dir(1'b1);
        rd(3'd2, v); check("R6 swap counts down", v, 32'd4);
        rd(3'd1, v); check("R10 reverse status", v, 32'd1);

        // R5: clock/direction
        drive(1'b0, 1'b0);
        wr(3'd0, C_EN | C_CD); wr(3'd2, 32'd0);
        for (int i = 0; i < 3; i++) begin drive(1'b1, 1'b0); drive(1'b0, 1'b0); end
        rd(3'd2, v); check("R5 clock/dir count up", v, 32'd3);
        drive(1'b0, 1'b1);
        rd(3'd2, v); check("R5 B change not counted", v, 32'd3);
        for (int i = 0; i < 3; i++) begin drive(1'b1, 1'b1); drive(1'b0, 1'b1); end
        rd(3'd2, v); check("R5 clock/dir count down", v, 32'd0);
        drive(1'b0, 1'b0);

        // R8: index mode
        wr(3'd0, C_EN | C_BOTH | C_IDX); wr(3'd2, 32'd5);
        @(negedge clk); idx = 1'b1; repeat (4) @(negedge clk);
        idx = 1'b0; repeat (4) @(negedge clk);
        rd(3'd2, v); check("R8 index clears position", v, 32'd0);
        wr(3'd2, 32'd5);
        begin
            logic [1:0] s;
            s = gst((gidx(ca, cb) + 1) % 4);
            @(negedge clk); idx = 1'b1; ph_a = s[1]; ph_b = s[0]; ca = s[1]; cb = s[0];
            repeat (4) @(negedge clk);
            idx = 1'b0; repeat (4) @(negedge clk);
        end
        rd(3'd2, v); check("R8 index wins over count", v, 32'd0);
        step_dir(1'b1);
        rd(3'd2, v); check("R8 count after index", v, 32'd1);
        wr(3'd2, 32'd9); step_dir(1'b1);
        rd(3'd2, v); check("R8 ceiling ignored", v, 32'd10);
        wr(3'd2, 32'd0); step_dir(1'b0);
        rd(3'd2, v); check("R8 full-range wrap", v, 32'hFFFF_FFFF);

        // R11, R12: speed window and predivider
        wr(3'd3, 32'hFFFF_FFFF);
        vel_case(0, 24, 32'd24);
        vel_case(2, 22, 32'd5);
        vel_case(7, 130, 32'd1);

        // R13: speed held while disabled
        wr(3'd0, C_VEL | C_BOTH);
        for (int i = 0; i < 8; i++) step_dir(1'b1);
        repeat (1200) @(negedge clk);
        rd(3'd5, v); check("R13 speed held while disabled", v, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule